// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a small data cache placed between a processor word port and a slower main-memory word port. It holds 32 words of 32 bits as 4 sets of 2 ways. Each way stores a 4-word line together with a tag, a valid flag and a dirty flag. Addresses are 10-bit byte addresses. Reads and writes that hit finish one cycle after the request. Writes change only the cache copy and mark the line dirty.

On a miss the block picks a victim way in the addressed set. It picks first in, first out, using one pointer per set. If the victim is dirty, its four words go back to memory first. The block then reads the whole aligned line from memory into the victim way. After that it replays the request internally, so the request completes as an ordinary hit. A write miss therefore allocates the line, merges the new word into it and leaves the line dirty.

The processor raises `req_i` and holds the request fields steady until it sees `ready_o` high for one cycle. The memory side moves one word per beat. `mem_valid_o` and its address and data stay steady until memory answers with `mem_ack_i`. Read data is presented on `mem_rdata_i` in the same cycle as the acknowledge.

Top module: `assoc_wb_cache`

## Requirements
- R1: After reset `ready_o`, `mem_valid_o` and `mem_we_o` are low and every line is invalid. The first access to any address is a miss, even when the stored tag would happen to match.
- R2: An access hits only when a way of the addressed set is valid and its stored tag equals address bits 9:6. The set is taken from bits 5:4. A read hit returns the word chosen by bits 3:2. `ready_o` is high in the cycle after the request for exactly one cycle, and the memory port stays idle.
- R3: A write hit changes only the cached word and sets that line's dirty flag. Memory is not written.
- R4: On a miss the line is filled with four memory reads. They run in ascending order, from the address with bits 3:0 cleared up to that address plus 12, with one word moving per acknowledged beat.
- R5: A miss whose victim is valid and dirty first writes the victim's four words back. The addresses are formed from the victim's tag and the set, in ascending word order, and all four writes come before the first fill read.
- R6: A miss whose victim is clean or invalid performs no memory writes.
- R7: A write miss allocates the line. The line is fetched, the new word is merged in, and the line is left dirty.
- R8: Each set's victim is the way named by its FIFO pointer. The pointer advances after every fill of that set, and hits leave it unchanged. A recently hit line can therefore still be the one evicted.
- R9: `ready_o` stays low during any memory transfer. While `mem_valid_o` is high and unacknowledged, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` (when writing) hold steady.
- R10: Address bits 1:0 are ignored. Every byte address within a word selects that same word.
- R11: `mem_valid_o` is high only during write-back or fill. `mem_we_o` is high only during write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Processor request, held until ready_o |
| we_i | input | 1 | Request is a write |
| addr_i | input | 10 | Byte address |
| wdata_i | input | 32 | Write word |
| rdata_o | output | 32 | Read word, valid with ready_o on a read |
| ready_o | output | 1 | One-cycle completion strobe |
| mem_valid_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Memory beat is a write |
| mem_addr_o | output | 10 | Memory word address (bits 1:0 zero) |
| mem_wdata_o | output | 32 | Write-back word |
| mem_rdata_i | input | 32 | Fill word, valid with mem_ack_i |
| mem_ack_i | input | 1 | Memory beat accepted |

## Verification
The hardest case to produce from the ports is a dirty victim being evicted from a set whose FIFO pointer differs from the order of recent use. That case checks both the write-back ordering and the FIFO choice at once. The bench reaches it on purpose. It runs a directed sequence in one set that hits an older line and then forces a conflict miss. It then writes to every word address, which fills every set with dirty lines, and reads them all back, which evicts each dirty line through write-back before the refill. A long run of pseudo-random accesses over a narrow tag range follows, with random byte offsets and random memory wait states. A reference model in the bench predicts hits, victims, beat counts and beat addresses.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WRITEBACK = 2'd1,
    ST_FILL      = 2'd2,
    ST_RESPOND   = 2'd3
  } cache_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int TAG_W = 4,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int LINES  = SETS * WAYS,
  localparam int LINE_W = SET_W + WAY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] lk_set_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic [WAY_W-1:0] vic_way_o,
  output logic             vic_valid_o,
  output logic             vic_dirty_o,
  output logic [TAG_W-1:0] vic_tag_o,
  input  logic             mark_i,
  input  logic             inst_i,
  input  logic [WAY_W-1:0] inst_way_i
);

  logic [TAG_W-1:0] tag_q   [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [WAY_W-1:0] fifo_q  [SETS];
  logic [WAYS-1:0]  way_hit;
  logic [LINE_W-1:0] vic_line;
  logic [LINE_W-1:0] mark_line;
  logic [LINE_W-1:0] inst_line;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    localparam logic [WAY_W-1:0] WIDX = WAY_W'(w);
    assign way_hit[w] = valid_q[{lk_set_i, WIDX}] &&
                        (tag_q[{lk_set_i, WIDX}] == lk_tag_i);
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (way_hit[w]) hit_way_o = WAY_W'(w);
    end
  end

  assign hit_o       = |way_hit;
  assign vic_way_o   = fifo_q[lk_set_i];
  assign vic_line    = {lk_set_i, vic_way_o};
  assign vic_valid_o = valid_q[vic_line];
  assign vic_dirty_o = dirty_q[vic_line];
  assign vic_tag_o   = tag_q[vic_line];
  assign mark_line   = {lk_set_i, hit_way_o};
  assign inst_line   = {lk_set_i, inst_way_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int l = 0; l < LINES; l++) tag_q[l] <= '0;
      for (int s = 0; s < SETS; s++) fifo_q[s] <= '0;
    end else begin
      if (inst_i) begin
        tag_q[inst_line]   <= lk_tag_i;
        valid_q[inst_line] <= 1'b1;
        dirty_q[inst_line] <= 1'b0;
        fifo_q[lk_set_i]   <= fifo_q[lk_set_i] + WAY_W'(1);
      end else if (mark_i) begin
        dirty_q[mark_line] <= 1'b1;
      end
    end
  end

  for (genvar l = 0; l < LINES; l++) begin : g_line_chk
    a_r1_valid_from_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(valid_q[l]) |-> $past(inst_i) && ($past(inst_line) == LINE_W'(l)));
    a_r3_dirty_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(dirty_q[l]) |-> $past(mark_i) && ($past(mark_line) == LINE_W'(l)));
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set_chk
    a_r8_fifo_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inst_i && lk_set_i == SET_W'(s)) |=> fifo_q[s] != $past(fifo_q[s]));
    a_r8_fifo_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(inst_i && lk_set_i == SET_W'(s)) |=> $stable(fifo_q[s]));
  end

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WORD_W = $clog2(LINE_WORDS),
  localparam int DEPTH  = SETS * WAYS * LINE_WORDS
) (
  input  logic               clk_i,
  input  logic [SET_W-1:0]   set_i,
  input  logic               wr_i,
  input  logic [WAY_W-1:0]   wr_way_i,
  input  logic [WORD_W-1:0]  wr_word_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [WORD_W-1:0]  rd_word_i,
  output logic [WAYS*DATA_W-1:0] rd_ways_o,
  input  logic [WAY_W-1:0]   wb_way_i,
  input  logic [WORD_W-1:0]  wb_word_i,
  output logic [DATA_W-1:0]  wb_data_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[{set_i, wr_way_i, wr_word_i}] <= wr_data_i;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    localparam logic [WAY_W-1:0] WIDX = WAY_W'(w);
    assign rd_ways_o[w*DATA_W +: DATA_W] = mem_q[{set_i, WIDX, rd_word_i}];
  end

  assign wb_data_o = mem_q[{set_i, wb_way_i, wb_word_i}];

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache2w_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  parameter int WAYS       = 2,
  parameter int TAG_W      = 4,
  localparam int WORD_W = $clog2(LINE_WORDS),
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              hit_i,
  input  logic              vic_valid_i,
  input  logic              vic_dirty_i,
  input  logic [WAY_W-1:0]  vic_way_i,
  input  logic [TAG_W-1:0]  vic_tag_i,
  input  logic              mem_ack_i,
  output cache_state_e      state_o,
  output logic [WORD_W-1:0] beat_o,
  output logic [WAY_W-1:0]  vic_way_o,
  output logic [TAG_W-1:0]  vic_tag_o,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic              fill_wr_o,
  output logic              install_o,
  output logic              cpu_wr_o,
  output logic              hit_acc_o
);

  localparam logic [WORD_W-1:0] LAST_BEAT = WORD_W'(LINE_WORDS - 1);

  cache_state_e      state_q, state_d;
  logic [WORD_W-1:0] beat_q, beat_d;
  logic [WAY_W-1:0]  vway_q;
  logic [TAG_W-1:0]  vtag_q;
  logic              miss_start;
  logic              last_beat;

  assign hit_acc_o  = (state_q == ST_IDLE) && req_i && hit_i;
  assign miss_start = (state_q == ST_IDLE) && req_i && !hit_i;
  assign cpu_wr_o   = hit_acc_o && we_i;
  assign last_beat  = (beat_q == LAST_BEAT);
  assign fill_wr_o  = (state_q == ST_FILL) && mem_ack_i;
  assign install_o  = fill_wr_o && last_beat;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: begin
        beat_d = '0;
        if (hit_acc_o)                                state_d = ST_RESPOND;
        else if (miss_start && vic_valid_i && vic_dirty_i) state_d = ST_WRITEBACK;
        else if (miss_start)                          state_d = ST_FILL;
      end
      ST_WRITEBACK: begin
        if (mem_ack_i) begin
          beat_d = beat_q + WORD_W'(1);
          if (last_beat) state_d = ST_FILL;
        end
      end
      ST_FILL: begin
        if (mem_ack_i) begin
          beat_d = beat_q + WORD_W'(1);
          if (last_beat) state_d = ST_IDLE;  // request replays as a hit
        end
      end
      ST_RESPOND: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      vway_q  <= '0;
      vtag_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      if (miss_start) begin
        vway_q <= vic_way_i;
        vtag_q <= vic_tag_i;
      end
    end
  end

  assign state_o     = state_q;
  assign beat_o      = beat_q;
  assign vic_way_o   = vway_q;
  assign vic_tag_o   = vtag_q;
  assign mem_valid_o = (state_q == ST_WRITEBACK) || (state_q == ST_FILL);
  assign mem_we_o    = (state_q == ST_WRITEBACK);

  a_r9_beat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ack_i) |=> mem_valid_o && $stable(mem_we_o) && $stable(beat_o));
  a_r5_wb_goes_to_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WRITEBACK) |=> (state_q == ST_WRITEBACK) || (state_q == ST_FILL));
  a_r4_fill_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL) |=> (state_q == ST_FILL) || (state_q == ST_IDLE));
  a_r2_respond_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESPOND) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/assoc_wb_cache.sv
module assoc_wb_cache
  import cache2w_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int SETS       = 4,
  parameter int WAYS       = 2,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);

  localparam int OFF_W  = $clog2(DATA_W / 8);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - SET_W - WORD_W - OFF_W;

  logic [TAG_W-1:0]  a_tag;
  logic [SET_W-1:0]  a_set;
  logic [WORD_W-1:0] a_word;

  assign a_tag  = addr_i[ADDR_W-1 -: TAG_W];
  assign a_set  = addr_i[OFF_W+WORD_W +: SET_W];
  assign a_word = addr_i[OFF_W +: WORD_W];

  logic              hit;
  logic [WAY_W-1:0]  hit_way;
  logic [WAY_W-1:0]  vic_way, vic_way_q;
  logic              vic_valid, vic_dirty;
  logic [TAG_W-1:0]  vic_tag, vic_tag_q;
  cache_state_e      state;
  logic [WORD_W-1:0] beat;
  logic              fill_wr, install, cpu_wr, hit_acc;
  logic [WAYS*DATA_W-1:0] rd_ways;
  logic [DATA_W-1:0] wb_data;
  logic              dwr;
  logic [WAY_W-1:0]  dwr_way;
  logic [WORD_W-1:0] dwr_word;
  logic [DATA_W-1:0] dwr_data;
  logic [DATA_W-1:0] rdata_q;

  cache_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) i_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lk_set_i   (a_set),
    .lk_tag_i   (a_tag),
    .hit_o      (hit),
    .hit_way_o  (hit_way),
    .vic_way_o  (vic_way),
    .vic_valid_o(vic_valid),
    .vic_dirty_o(vic_dirty),
    .vic_tag_o  (vic_tag),
    .mark_i     (cpu_wr),
    .inst_i     (install),
    .inst_way_i (vic_way_q)
  );

  cache_ctrl #(.LINE_WORDS(LINE_WORDS), .WAYS(WAYS), .TAG_W(TAG_W)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .hit_i      (hit),
    .vic_valid_i(vic_valid),
    .vic_dirty_i(vic_dirty),
    .vic_way_i  (vic_way),
    .vic_tag_i  (vic_tag),
    .mem_ack_i  (mem_ack_i),
    .state_o    (state),
    .beat_o     (beat),
    .vic_way_o  (vic_way_q),
    .vic_tag_o  (vic_tag_q),
    .mem_valid_o(mem_valid_o),
    .mem_we_o   (mem_we_o),
    .fill_wr_o  (fill_wr),
    .install_o  (install),
    .cpu_wr_o   (cpu_wr),
    .hit_acc_o  (hit_acc)
  );

  // Fill beats and processor write hits never coincide (different states).
  assign dwr      = fill_wr || cpu_wr;
  assign dwr_way  = fill_wr ? vic_way_q   : hit_way;
  assign dwr_word = fill_wr ? beat        : a_word;
  assign dwr_data = fill_wr ? mem_rdata_i : wdata_i;

  cache_data_store #(
    .SETS(SETS), .WAYS(WAYS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)
  ) i_data (
    .clk_i     (clk_i),
    .set_i     (a_set),
    .wr_i      (dwr),
    .wr_way_i  (dwr_way),
    .wr_word_i (dwr_word),
    .wr_data_i (dwr_data),
    .rd_word_i (a_word),
    .rd_ways_o (rd_ways),
    .wb_way_i  (vic_way_q),
    .wb_word_i (beat),
    .wb_data_o (wb_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_q <= '0;
    else if (hit_acc && !we_i)  rdata_q <= rd_ways[hit_way*DATA_W +: DATA_W];
  end

  assign rdata_o     = rdata_q;
  assign ready_o     = (state == ST_RESPOND);
  assign mem_wdata_o = wb_data;
  assign mem_addr_o  = {(state == ST_WRITEBACK) ? vic_tag_q : a_tag, a_set, beat, {OFF_W{1'b0}}};

  a_r9_no_ready_in_transfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> !ready_o);
  a_r9_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ack_i) |=> $stable(mem_addr_o));
  a_r9_wdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_we_o && !mem_ack_i) |=> $stable(mem_wdata_o));
  a_r2_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  a_r11_we_only_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_valid_o);

endmodule

// File: tb/test_assoc_wb_cache.sv
module test_assoc_wb_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready;
  logic        mem_valid, mem_we;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #10 clk = ~clk;

  assoc_wb_cache i_assoc_wb_cache (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] x = v;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // memory model and reference state
  logic [31:0] mem    [256];
  logic [31:0] golden [256];
  logic [3:0]  m_tag  [8];
  logic        m_valid[8];
  logic        m_dirty[8];
  logic        m_fifo [4];
  int          rd_cnt = 0, wr_cnt = 0, wait_cnt = 0;
  logic [5:0]  exp_fill_line = '0, exp_wb_line = '0;
  logic [31:0] seed_m = 32'h1234_5678;

  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (rst_n && mem_valid) begin
      if (wait_cnt > 0) wait_cnt--;
      else begin
        mem_ack = 1'b1;
        if (mem_we) begin
          chk(rd_cnt == 0, "R5 write-back before fill", 32'(rd_cnt), 32'd0);
          chk(mem_addr == {exp_wb_line, 2'(wr_cnt), 2'b00}, "R5 write-back address",
              32'(mem_addr), 32'({exp_wb_line, 2'(wr_cnt), 2'b00}));
          mem[mem_addr[9:2]] = mem_wdata;
          wr_cnt++;
        end else begin
          chk(mem_addr == {exp_fill_line, 2'(rd_cnt), 2'b00}, "R4 fill address",
              32'(mem_addr), 32'({exp_fill_line, 2'(rd_cnt), 2'b00}));
          mem_rdata = mem[mem_addr[9:2]];
          rd_cnt++;
        end
        seed_m = xs(seed_m);
        wait_cnt = int'(seed_m % 3);
      end
    end
  end

  task automatic access(input bit w, input logic [9:0] a, input logic [31:0] wd, input string tg);
    logic [1:0] s = a[5:4];
    logic [3:0] t = a[9:6];
    bit hit = 0;
    int v, cyc = 0, exp_rd, exp_wr;
    bit r9_bad = 0, r11_bad = 0;
    for (int k = 0; k < 2; k++)
      if (m_valid[s*2+k] && m_tag[s*2+k] == t) hit = 1;
    v = s*2 + int'(m_fifo[s]);
    exp_rd = hit ? 0 : 4;
    exp_wr = (!hit && m_valid[v] && m_dirty[v]) ? 4 : 0;
    exp_fill_line = {t, s};
    exp_wb_line   = {m_tag[v], s};
    if (!hit) begin
      m_tag[v] = t; m_valid[v] = 1'b1; m_dirty[v] = 1'b0;
      m_fifo[s] = ~m_fifo[s];
    end
    if (w) begin
      golden[a[9:2]] = wd;
      for (int k = 0; k < 2; k++)
        if (m_valid[s*2+k] && m_tag[s*2+k] == t) m_dirty[s*2+k] = 1'b1;
    end
    rd_cnt = 0; wr_cnt = 0;
    req = 1'b1; we = w; addr = a; wdata = wd;
    do begin
      @(negedge clk);
      cyc++;
      if (mem_valid && ready) r9_bad = 1;
      if (hit && mem_valid) r11_bad = 1;
    end while (!ready && cyc < 3000);
    chk(cyc < 3000, "R9 completion", 32'(cyc), 32'd0);
    req = 1'b0;
    chk(rd_cnt == exp_rd, tg, 32'(rd_cnt), 32'(exp_rd));
    chk(wr_cnt == exp_wr, exp_wr != 0 ? "R5 write-back beats" : "R6 no write-back",
        32'(wr_cnt), 32'(exp_wr));
    chk(!r9_bad, "R9 ready during transfer", 32'(r9_bad), 32'd0);
    if (hit) begin
      chk(cyc == 1, "R2 hit latency", 32'(cyc), 32'd1);
      chk(!r11_bad, "R11 no traffic on hit", 32'(r11_bad), 32'd0);
    end
    if (!w)
      chk(rdata == golden[a[9:2]], a[1:0] != 0 ? "R10 offset ignored" : "R2 read data",
          rdata, golden[a[9:2]]);
    @(negedge clk);
    chk(!ready, "R2 ready single cycle", 32'(ready), 32'd0);
  endtask

  initial begin : watchdog
    repeat (190000) @(negedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] r = 32'hCAFE_F00D;
    for (int i = 0; i < 256; i++) begin
      mem[i] = (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
      golden[i] = mem[i];
    end
    for (int i = 0; i < 8; i++) begin m_tag[i] = '0; m_valid[i] = 0; m_dirty[i] = 0; end
    for (int i = 0; i < 4; i++) m_fifo[i] = 0;
    repeat (3) @(negedge clk);
    chk(!ready && !mem_valid && !mem_we, "R1 outputs in reset",
        {29'd0, ready, mem_valid, mem_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ready && !mem_valid, "R1 idle after reset", {30'd0, ready, mem_valid}, 32'd0);

    // R1: tag 0 matches reset tag value but line is invalid -> miss
    access(0, 10'h000, '0, "R1 first access misses");
    // R8: FIFO order in set 1 (tags 1,2 fill; hit 1; tag 3 evicts 1 not 2)
    access(0, 10'h050, '0, "R4 fill");
    access(0, 10'h094, '0, "R4 fill");
    access(0, 10'h058, '0, "R8 hit keeps pointer");
    access(0, 10'h0D0, '0, "R8 victim by pointer");
    access(0, 10'h09C, '0, "R8 older-used line kept");
    access(0, 10'h054, '0, "R8 evicted line misses");
    // R7 write miss allocates then merges; R3 write hit stays in cache
    access(1, 10'h164, 32'hA5A5_0001, "R7 write miss allocates");
    access(0, 10'h164, '0, "R7 merged word hits");
    access(1, 10'h168, 32'hA5A5_0002, "R3 write hit no traffic");
    access(0, 10'h1E0, '0, "R4 fill");
    access(0, 10'h220, '0, "R5 dirty victim evicted");
    access(0, 10'h167, '0, "R7 merged word from memory");

    // sweep: write every word, then read every word back
    for (int i = 0; i < 256; i++)
      access(1, 10'(i*4), 32'hD000_0000 ^ (32'(i) * 32'h0101_0113), "R7 sweep write");
    for (int i = 0; i < 256; i++)
      access(0, 10'(i*4 + (i % 4)), '0, "R4 sweep read");

    // random mix over a narrow tag range with random byte offsets (R10)
    for (int i = 0; i < 1500; i++) begin
      logic [9:0] a;
      r = xs(r);
      a = {r[12] & r[13], r[14] & r[15], r[1:0], r[21:16]};
      access(r[30], a, xs(r ^ 32'h77), "R2 random lookup");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule